// File: doc/BRIEF.md
# SDRAM Burst Data Path

This block sits beside the command logic of one 16-bit SDRAM-style port and handles everything about a column access that unfolds over several clocks. When a read or write command is accepted, it expands the starting column into the sequence of beat addresses for the programmed burst length, in sequential or interleaved order. For writes it puts the beat data on the DQ output bus with output enable in the same clock, with lanes blocked by the byte mask sampled with that beat. For reads it captures the DQ input bus after the programmed CAS latency. The mask for a read beat is the one sampled two clocks before the capture. The DQ pins appear as a separate input bus, output bus and output enable.

A new read or write command cuts short any burst in flight and starts its own beat 0 in the same clock. A stop command ends the address and write-data beats at once. Read beats already issued still deliver their data. The outputs are flowing streams with a valid flag and no ready. The memory timing is fixed, so there is no back-pressure and the consumer must take every valid beat in the clock it appears. The burst length and order are latched with each command. The CAS latency is used live and must stay steady while reads are in flight.

Top module: `sdram_burst_dp`

## Requirements
- R1: While `rst_n` is low, `col_valid`, `dq_oe`, `rd_valid`, `wr_lane_en` and `rd_lane_en` are all 0.
- R2: A command with `cfg_blen` code 0, 1, 2 or 3 produces 1, 2, 4 or 8 beats on consecutive clocks. Each beat shows `col_valid`=1 one clock after the edge that issued it. `col_write` follows `cmd_write`.
- R3: With `cfg_ilv`=0, beat k's column keeps the starting column's bits above the burst block. Its low bits are (start + k) modulo the burst length, so the order wraps inside the aligned block.
- R4: With `cfg_ilv`=1, beat k's low bits within the burst block are start XOR k. The higher bits are unchanged.
- R5: For a write beat issued at an edge, `dq_oe` is 1 in the following clock and `dq_out` carries `wr_data` from that same edge. `dq_oe` is 0 in every other clock.
- R6: The write mask has latency 0. `dqm[i]`=1 at a write beat's edge clears `wr_lane_en[i]` and drives lane i (bits 8i+7..8i) of `dq_out` to 0. Otherwise `wr_lane_en[i]`=1.
- R7: A read beat issued at edge t is captured from `dq_in` at edge t+CL, where CL is 3 if `cfg_cl3`=1 and 2 otherwise. `rd_valid`=1 and `rd_data` shows the capture in the following clock. Otherwise `rd_valid` is 0.
- R8: The read mask has latency 2. `dqm[i]` sampled at edge e-2 masks the beat captured at edge e, giving `rd_lane_en[i]`=0 and lane i of `rd_data` zero. `rd_lane_en` is 0 whenever `rd_valid` is 0.
- R9: `cmd_stop` without `cmd_valid` ends the current burst. No beat is issued at that edge or later. Read beats issued earlier still return data.
- R10: A command arriving mid-burst abandons the remaining beats. It issues its own beat 0 at that edge with the starting column unchanged, and its burst then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Read or write command this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_stop | input | 1 | Stop the burst in flight |
| cmd_col | input | 10 | Starting column |
| cfg_blen | input | 2 | Burst length code: 1, 2, 4 or 8 beats |
| cfg_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cfg_cl3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| dqm | input | 2 | Byte mask, one bit per lane |
| wr_data | input | 16 | Write beat data |
| dq_in | input | 16 | DQ pins, input side |
| col_valid | output | 1 | A beat was issued |
| col_write | output | 1 | The beat is a write |
| col_addr | output | 10 | Column of the beat |
| dq_oe | output | 1 | DQ output enable |
| dq_out | output | 16 | DQ pins, output side, masked lanes zero |
| wr_lane_en | output | 2 | Write lanes not masked |
| rd_valid | output | 1 | Read capture valid |
| rd_data | output | 16 | Captured read data, masked lanes zero |
| rd_lane_en | output | 2 | Read lanes not masked |

## Verification
The hardest case to reach is the overlap of a stopped or truncated burst with read captures still in the latency pipe, under a mask that changes every clock. Here the read-mask history must line up with beats issued before the new command. The stimulus gets there in two ways. Directed sequences stop and re-issue in the middle of 8-beat reads at both latencies. A pseudo-random phase then issues commands, stops and per-clock masks densely, so captures from one burst land while the next one runs. A behavioural model keyed by cycle number predicts every output each clock.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  // burst length code: beats = 1 << code
  typedef enum logic [1:0] {
    BLEN_1 = 2'd0,
    BLEN_2 = 2'd1,
    BLEN_4 = 2'd2,
    BLEN_8 = 2'd3
  } blen_e;

  localparam int MAX_BEATS = 8;
  localparam int BEAT_W    = $clog2(MAX_BEATS);
endpackage

// File: rtl/sdb_burst_seq.sv
module sdb_burst_seq
  import sdb_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       cfg_blen,
  input  logic             cfg_ilv,
  output logic             iss_v,
  output logic             iss_wr,
  output logic [COL_W-1:0] iss_col
);
  logic              act_q;
  logic              wr_q;
  logic [COL_W-1:0]  base_q;
  blen_e             blen_q;
  logic              ilv_q;
  logic [BEAT_W-1:0] k_q;
  logic [BEAT_W-1:0] last_k;

  function automatic logic [COL_W-1:0] beat_addr(
    input logic [COL_W-1:0]  base,
    input logic [1:0]        code,
    input logic              ilv,
    input logic [BEAT_W-1:0] k
  );
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] kx;
    logic [COL_W-1:0] low;
    m   = COL_W'((32'd1 << code) - 32'd1);
    kx  = COL_W'(k);
    low = ilv ? ((base ^ kx) & m) : ((base + kx) & m);
    return (base & ~m) | low;
  endfunction

  assign last_k = BEAT_W'((32'd1 << blen_q) - 32'd1);

  always_comb begin
    iss_v   = 1'b0;
    iss_wr  = 1'b0;
    iss_col = '0;
    if (cmd_valid) begin
      iss_v   = 1'b1;
      iss_wr  = cmd_write;
      iss_col = cmd_col;
    end else if (!cmd_stop && act_q) begin
      iss_v   = 1'b1;
      iss_wr  = wr_q;
      iss_col = beat_addr(base_q, blen_q, ilv_q, k_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      blen_q <= BLEN_1;
      ilv_q  <= 1'b0;
      k_q    <= '0;
    end else if (cmd_valid) begin
      act_q  <= (cfg_blen != BLEN_1);
      wr_q   <= cmd_write;
      base_q <= cmd_col;
      blen_q <= blen_e'(cfg_blen);
      ilv_q  <= cfg_ilv;
      k_q    <= BEAT_W'(1);
    end else if (cmd_stop) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      k_q <= k_q + BEAT_W'(1);
      if (k_q == last_k) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdb_wr_path.sv
module sdb_wr_path #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_beat,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] dqm,
  output logic             dq_oe,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] wr_lane_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq_oe <= 1'b0;
    else        dq_oe <= wr_beat;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_lane_en[g]                 <= 1'b0;
        dq_out[g*LANE_W +: LANE_W]    <= '0;
      end else begin
        wr_lane_en[g]                 <= wr_beat & ~dqm[g];
        dq_out[g*LANE_W +: LANE_W]    <= (wr_beat && !dqm[g]) ?
                                         wr_data[g*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/sdb_rd_path.sv
module sdb_rd_path #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int CL_MAX = 3,
  localparam int DW    = LANES * LANE_W,
  localparam int MASK_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_beat,
  input  logic             cfg_cl3,
  input  logic [LANES-1:0] dqm,
  input  logic [DW-1:0]    dq_in,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [LANES-1:0] rd_lane_en
);
  logic [CL_MAX-1:0]   pipe_q;
  logic [LANES-1:0]    mhist_q [MASK_LAT];
  logic                cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[CL_MAX-2:0], rd_beat};
  end

  for (genvar h = 0; h < MASK_LAT; h++) begin : g_mhist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mhist_q[h] <= '0;
      else if (h == 0) mhist_q[h] <= dqm;
      else             mhist_q[h] <= mhist_q[(h == 0) ? 0 : h-1];
    end
  end

  assign cap = cfg_cl3 ? pipe_q[2] : pipe_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_lane_en[g]               <= 1'b0;
        rd_data[g*LANE_W +: LANE_W] <= '0;
      end else begin
        rd_lane_en[g]               <= cap & ~mhist_q[MASK_LAT-1][g];
        rd_data[g*LANE_W +: LANE_W] <= (cap && !mhist_q[MASK_LAT-1][g]) ?
                                       dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/sdram_burst_dp.sv
module sdram_burst_dp #(
  parameter int COL_W  = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       cfg_blen,
  input  logic             cfg_ilv,
  input  logic             cfg_cl3,
  input  logic [LANES-1:0] dqm,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    dq_in,
  output logic             col_valid,
  output logic             col_write,
  output logic [COL_W-1:0] col_addr,
  output logic             dq_oe,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] wr_lane_en,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [LANES-1:0] rd_lane_en
);
  logic             iss_v;
  logic             iss_wr;
  logic [COL_W-1:0] iss_col;

  sdb_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_stop(cmd_stop),
    .cmd_col(cmd_col), .cfg_blen(cfg_blen), .cfg_ilv(cfg_ilv),
    .iss_v(iss_v), .iss_wr(iss_wr), .iss_col(iss_col)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_write <= 1'b0;
      col_addr  <= '0;
    end else begin
      col_valid <= iss_v;
      col_write <= iss_v & iss_wr;
      col_addr  <= iss_v ? iss_col : '0;
    end
  end

  sdb_wr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_beat(iss_v & iss_wr), .wr_data(wr_data), .dqm(dqm),
    .dq_oe(dq_oe), .dq_out(dq_out), .wr_lane_en(wr_lane_en)
  );

  sdb_rd_path #(.LANES(LANES), .LANE_W(LANE_W), .CL_MAX(3)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_beat(iss_v & ~iss_wr), .cfg_cl3(cfg_cl3), .dqm(dqm), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_lane_en(rd_lane_en)
  );
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
  parameter int COL_W = 10,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic             cmd_stop,
  input logic [COL_W-1:0] cmd_col,
  input logic             cfg_cl3,
  input logic             col_valid,
  input logic             col_write,
  input logic [COL_W-1:0] col_addr,
  input logic             dq_oe,
  input logic [LANES-1:0] wr_lane_en,
  input logic             rd_valid,
  input logic [LANES-1:0] rd_lane_en
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!col_valid && !dq_oe && !rd_valid && wr_lane_en == '0 && rd_lane_en == '0));

  a_r5_oe_with_write_beat: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == (col_valid && col_write));

  a_r6_lanes_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> wr_lane_en == '0);

  a_r8_rd_lanes_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_lane_en == '0);

  a_r7_cl2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cfg_cl3) |-> $past(col_valid && !col_write, 2));

  a_r7_cl3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cfg_cl3) |-> $past(col_valid && !col_write, 3));

  a_r9_stop_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_stop && !cmd_valid) |-> !col_valid);

  a_r10_cmd_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid) |-> (col_valid && col_addr == $past(cmd_col) &&
                          col_write == $past(cmd_write)));
endmodule

bind sdram_burst_dp sdb_checker #(.COL_W(COL_W), .LANES(LANES)) u_chk (.*);

// File: tb/tb_sdram_burst_dp.sv
`timescale 1ns/1ps
module tb_sdram_burst_dp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_write = 0, cmd_stop = 0;
  logic [9:0]  cmd_col = '0;
  logic [1:0]  cfg_blen = '0;
  logic        cfg_ilv = 0, cfg_cl3 = 0;
  logic [1:0]  dqm = '0;
  logic [15:0] wr_data = '0, dq_in = '0;
  logic        col_valid, col_write, dq_oe, rd_valid;
  logic [9:0]  col_addr;
  logic [15:0] dq_out, rd_data;
  logic [1:0]  wr_lane_en, rd_lane_en;

  sdram_burst_dp dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag_v = "R2";

  // behavioural model state keyed by cycle number
  bit         pv [int];
  bit         pw [int];
  int         pc [int];
  bit         due[int];
  logic [1:0]  mh[int];
  logic [15:0] dh[int];

  bit e_cv, e_cw, e_oe, e_rv;
  int e_ca;
  logic [15:0] e_dq, e_rd;
  logic [1:0]  e_wl, e_rl;
  logic [31:0] lfsr = 32'hACE1_2345;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? 8'h00 : d[15:8], m[0] ? 8'h00 : d[7:0]};
  endfunction

  task automatic model();
    int n, s, blk, off;
    mh[cyc] = dqm;
    dh[cyc] = dq_in;
    if (cmd_valid) begin
      for (int j = 0; j < 8; j++) if (pv.exists(cyc + j)) pv.delete(cyc + j);
      n = 1 << cfg_blen;
      s = int'(cmd_col);
      blk = (s / n) * n;
      off = s % n;
      for (int j = 0; j < n; j++) begin
        pv[cyc + j] = 1;
        pw[cyc + j] = cmd_write;
        pc[cyc + j] = cfg_ilv ? blk + (off ^ j) : blk + ((off + j) % n);
      end
    end else if (cmd_stop) begin
      for (int j = 0; j < 8; j++) if (pv.exists(cyc + j)) pv.delete(cyc + j);
    end
    e_cv = pv.exists(cyc);
    e_cw = e_cv && pw[cyc];
    e_ca = e_cv ? pc[cyc] : 0;
    if (e_cv && !e_cw) due[cyc + (cfg_cl3 ? 3 : 2)] = 1;
    e_oe = e_cw;
    e_dq = e_oe ? lane_mask(wr_data, dqm) : 16'h0;
    e_wl = e_oe ? ~dqm : 2'b00;
    e_rv = due.exists(cyc);
    e_rd = e_rv ? lane_mask(dh[cyc], mh[cyc - 2]) : 16'h0;
    e_rl = e_rv ? ~mh[cyc - 2] : 2'b00;
  endtask

  task automatic compare();
    chk(tag_v, col_valid, e_cv);
    chk("R2", col_write, e_cw);
    chk(cfg_ilv ? "R4" : "R3", col_addr, e_ca);
    chk("R5", dq_oe, e_oe);
    chk("R6", {dq_out, wr_lane_en}, {e_dq, e_wl});
    chk("R7", {rd_valid, rd_data}, {e_rv, e_rd});
    chk("R8", rd_lane_en, e_rl);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit cv, input bit cw, input bit cs, input int col,
                      input logic [1:0] m);
    cmd_valid = cv; cmd_write = cw; cmd_stop = cs; cmd_col = 10'(col);
    dqm = m;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    wr_data = lfsr[15:0];
    dq_in = lfsr[31:16];
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'b00);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1", {col_valid, dq_oe, rd_valid, wr_lane_en, rd_lane_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: sequential reads at CL2, each length, start mid block
    cfg_ilv = 0; cfg_cl3 = 0;
    for (int b = 0; b < 4; b++) begin
      cfg_blen = 2'(b);
      step(1, 0, 0, 10'h3F6, 2'b00);
      idle(12);
    end
    // R4: interleaved
    cfg_ilv = 1;
    for (int b = 0; b < 4; b++) begin
      cfg_blen = 2'(b);
      step(1, 0, 0, 10'h1A5, 2'b00);
      idle(12);
    end
    // R5/R6: writes of 8 with a mask changing every beat
    cfg_ilv = 0; cfg_blen = 2'd3;
    step(1, 1, 0, 10'h05D, 2'b01);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 2'(i + 2));
    idle(6);
    // R7/R8: CL3 reads with moving mask
    cfg_cl3 = 1;
    step(1, 0, 0, 10'h222, 2'b10);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 2'(i));
    idle(6);
    // R9: stop mid burst, both latencies
    tag_v = "R9";
    for (int c = 0; c < 2; c++) begin
      cfg_cl3 = c[0];
      step(1, 0, 0, 10'h10B, 2'b00);
      step(0, 0, 0, 0, 2'b01);
      step(0, 0, 0, 0, 2'b10);
      step(0, 0, 1, 0, 2'b11);
      idle(8);
    end
    // R10: new commands truncate
    tag_v = "R10";
    cfg_ilv = 1;
    step(1, 0, 0, 10'h0F3, 2'b00);
    step(0, 0, 0, 0, 2'b00);
    step(1, 1, 0, 10'h2C6, 2'b10);
    step(0, 0, 0, 0, 2'b01);
    step(1, 0, 0, 10'h3FF, 2'b00);
    idle(12);
    // pseudo-random mix
    tag_v = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = lfsr;
      cfg_blen = r[5:4];
      cfg_ilv = r[6];
      if (i % 150 == 0) begin
        idle(6);
        cfg_cl3 = r[7];
      end
      step(r[11:8] == 4'd0, r[12], r[15:13] == 3'd0, int'(r[25:16]), r[27:26]);
    end
    idle(8);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule